// File: doc/BRIEF.md
# Dual-Channel Disk Controller I/O Window Decoder

This block sits between a host I/O request stream and the register files of a two-channel disk controller. Five base addresses are loaded from configuration writes. Each incoming read or write is matched against five windows built from them: a command window for each channel, a control window for each channel, and one bus-master window shared by both channels. The winning window raises a single-cycle select strobe toward its target, along with a local register offset and the write data to forward. The data a target presents is captured into a one-deep response register, together with a claim flag.

Requests use a valid/ready handshake, and so do responses. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in that same cycle (`rsp_ready` high). A response stays on the port, unchanged, until `rsp_ready` takes it. Target read data must be valid in the same cycle as the select strobe. Base loading is a plain control path with no handshake.

Top module: `ide_io_decoder`

## Requirements
- R1: Loading a base (slot 0 channel-0 command, 1 channel-1 command, 2 channel-0 control, 3 channel-1 control, 4 bus master) stores the value with bits 1:0 cleared. Slot numbers 5 to 7 change nothing.
- R2: A command window hits when the address with bits 2:0 cleared equals the stored base. The offset is address bits 2:0. A base with bit 2 set therefore never hits.
- R3: A control window hits when the address with bits 1:0 cleared equals the base. The offset is address bits 1:0 plus CTRL_OFS (default 8, giving offsets 8 to 11).
- R4: The bus-master window hits when the address with bits 3:0 cleared equals the base. The offset is address bits 3:0.
- R5: Overlapping hits resolve in this order: channel-0 command, channel-1 command, channel-0 control, channel-1 control, bus master. `tgt_sel` bit n marks slot n. A hit is claimed (`rsp_claim`=1).
- R6: A read that hits nothing returns 0xFFFFFFFF with `rsp_claim`=0. A write that hits nothing gives `rsp_claim`=0 and `rsp_rdata`=0.
- R7: A bus-master write forwards only `req_wdata[7:0]`, with upper bits zero. Channel targets get all 32 bits.
- R8: The data of a claimed read is masked to the size (`req_size` 0 = byte, 1 = 16 bits, 2 or 3 = 32 bits). Bus-master data is zero-extended from 8 bits. A claimed write returns 0.
- R9: `tgt_sel` is at most one-hot and is non-zero only in a cycle where a request is accepted. It is driven combinationally in that cycle.
- R10: The response appears in the cycle after acceptance and holds while `rsp_ready` is low. `req_ready` = not `rsp_valid` or `rsp_ready`.
- R11: A base load in the same cycle as a request takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears bases and response |
| cfg_ld | input | 1 | Base load strobe |
| cfg_idx | input | 3 | Base slot to load |
| cfg_base | input | ADDR_W | Base value to load |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | I/O address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| tgt_sel | output | 5 | Per-target select strobe |
| tgt_wr | output | 1 | Selected access is a write |
| tgt_offset | output | OFS_W | Local register offset |
| tgt_wdata | output | 32 | Forwarded write data |
| ch0_rdata | input | 32 | Channel 0 read data |
| ch1_rdata | input | 32 | Channel 1 read data |
| bm_rdata | input | 8 | Bus-master read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Returned read value |
| rsp_claim | output | 1 | Access hit a window |

## Verification
Two functions can meet in one cycle. The first is a base load colliding with a request that decodes against that same base. The bench drives both in one cycle and expects the old base to decide that access and the new base to decide the next one. The second is a response drain coinciding with a new acceptance under a stalling `rsp_ready`. The reference model predicts `req_ready` and the held response in every cycle.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NUM_WIN = 5;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 32;

  typedef enum logic [IDX_W-1:0] {
    WIN_CMD0 = 3'd0,
    WIN_CMD1 = 3'd1,
    WIN_CTL0 = 3'd2,
    WIN_CTL1 = 3'd3,
    WIN_BM   = 3'd4
  } win_e;

  // number of address bits ignored by each window
  function automatic int win_low_bits(input int w);
    if (w < 2)      return 3;
    else if (w < 4) return 2;
    else            return 4;
  endfunction
endpackage

// File: rtl/ide_base_bank.sv
module ide_base_bank #(
  parameter int ADDR_W = 32,
  parameter int NUM    = 5,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [ADDR_W-1:0] ld_data,
  output logic [ADDR_W-1:0] base_o [NUM]
);
  for (genvar i = 0; i < NUM; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_o[i] <= '0;
      else if (ld && ld_idx == IDX_W'(i))
        base_o[i] <= {ld_data[ADDR_W-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/ide_win_cmp.sv
module ide_win_cmp #(
  parameter int ADDR_W = 32,
  parameter int LOW    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << LOW;
  assign hit = (addr & KEEP) == base;
endmodule

// File: rtl/ide_rsp_stage.sv
module ide_rsp_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_write,
  input  logic              hit_any,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] raw,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_claim,
  output logic              req_ready
);
  logic [DATA_W-1:0] sized;

  always_comb begin
    case (size)
      2'd0:    sized = {{(DATA_W-8){1'b0}},  raw[7:0]};
      2'd1:    sized = {{(DATA_W-16){1'b0}}, raw[15:0]};
      default: sized = raw;
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_claim <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_claim <= hit_any;
      if (is_write)     rsp_rdata <= '0;
      else if (hit_any) rsp_rdata <= sized;
      else              rsp_rdata <= '1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CTRL_OFS = 8,
  localparam int OFS_RAW = $clog2(CTRL_OFS + 4),
  localparam int OFS_W   = (OFS_RAW > 4) ? OFS_RAW : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ld,
  input  logic [2:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [4:0]        tgt_sel,
  output logic              tgt_wr,
  output logic [OFS_W-1:0]  tgt_offset,
  output logic [31:0]       tgt_wdata,
  input  logic [31:0]       ch0_rdata,
  input  logic [31:0]       ch1_rdata,
  input  logic [7:0]        bm_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_claim
);
  logic [ADDR_W-1:0] base [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  win_e               win;
  logic               hit_any;
  logic               accept;
  logic [DATA_W-1:0]  raw;

  ide_base_bank #(.ADDR_W(ADDR_W), .NUM(NUM_WIN), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld(cfg_ld), .ld_idx(cfg_idx),
    .ld_data(cfg_base), .base_o(base)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ide_win_cmp #(.ADDR_W(ADDR_W), .LOW(win_low_bits(w))) u_cmp (
      .addr(req_addr), .base(base[w]), .hit(hit[w])
    );
  end

  // lowest slot number wins
  always_comb begin
    win     = WIN_CMD0;
    hit_any = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        win     = win_e'(w);
        hit_any = 1'b1;
      end
    end
  end

  assign accept = req_valid && req_ready;
  assign tgt_sel = (accept && hit_any) ? (5'b00001 << win) : 5'b00000;
  assign tgt_wr  = accept && req_write;

  always_comb begin
    case (win)
      WIN_CMD0, WIN_CMD1: tgt_offset = OFS_W'(req_addr[2:0]);
      WIN_CTL0, WIN_CTL1: tgt_offset = OFS_W'(CTRL_OFS) + OFS_W'(req_addr[1:0]);
      default:            tgt_offset = OFS_W'(req_addr[3:0]);
    endcase
  end

  assign tgt_wdata = (win == WIN_BM) ? {24'b0, req_wdata[7:0]} : req_wdata;

  always_comb begin
    case (win)
      WIN_CMD0, WIN_CTL0: raw = ch0_rdata;
      WIN_CMD1, WIN_CTL1: raw = ch1_rdata;
      default:            raw = {24'b0, bm_rdata};
    endcase
  end

  ide_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_write(req_write),
    .hit_any(hit_any), .size(req_size), .raw(raw), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_claim(rsp_claim),
    .req_ready(req_ready)
  );
endmodule

// File: rtl/ide_io_decoder_chk.sv
module ide_io_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [4:0]  tgt_sel,
  input logic        tgt_wr,
  input logic [31:0] tgt_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        rsp_claim
);
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  assert_sel_only_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel != 5'b0) |-> (req_valid && req_ready));

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_claim)));

  assert_hit_claimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel != 5'b0) |=> rsp_claim);

  assert_miss_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tgt_sel == 5'b0 && !req_write)
      |=> (!rsp_claim && rsp_rdata == 32'hFFFF_FFFF));

  assert_miss_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tgt_sel == 5'b0 && req_write) |=> !rsp_claim);

  assert_bm_low_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel[4] && tgt_wr) |-> (tgt_wdata[31:8] == 24'b0));

  assert_byte_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel != 5'b0 && !req_write && req_size == 2'd0) |=> (rsp_rdata[31:8] == 24'b0));
endmodule

bind ide_io_decoder ide_io_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_size(req_size), .tgt_sel(tgt_sel), .tgt_wr(tgt_wr),
  .tgt_wdata(tgt_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_claim(rsp_claim)
);

// File: tb/ide_io_decoder_bench.sv
`timescale 1ns/1ps
module ide_io_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_ld = 0;
  logic [2:0]  cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic        req_write = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_size = 2;
  logic [31:0] req_wdata = 0;
  logic [4:0]  tgt_sel;
  logic        tgt_wr;
  logic [3:0]  tgt_offset;
  logic [31:0] tgt_wdata;
  logic [31:0] ch0_rdata = 32'hA1B2C3D4;
  logic [31:0] ch1_rdata = 32'h55667788;
  logic [7:0]  bm_rdata  = 8'h9E;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [31:0] rsp_rdata;
  logic        rsp_claim;

  int total = 0, bad = 0;
  bit done = 0, stall = 0;
  int cyc = 0;
  string cur = "R2";

  always #10 clk = ~clk;

  ide_io_decoder u_ide_io_decoder (.*);

  // reference model state
  logic [31:0] m_base [5];
  bit          m_rv;
  logic [31:0] m_rdata;
  bit          m_claim;

  function automatic int m_find(input logic [31:0] a);
    int masks [5] = '{7, 7, 3, 3, 15};
    for (int w = 0; w < 5; w++)
      if ((a & ~masks[w]) == m_base[w]) return w;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_base[i] = 0;
      m_rv = 0; m_rdata = 0; m_claim = 0;
    end else begin
      int t;
      bit acc;
      logic [31:0] raw;
      t = m_find(req_addr);
      acc = req_valid && (!m_rv || rsp_ready);
      if (acc) begin
        m_rv = 1;
        m_claim = (t >= 0);
        if (req_write) m_rdata = 0;
        else if (t < 0) m_rdata = 32'hFFFFFFFF;
        else begin
          raw = (t == 4) ? {24'b0, bm_rdata} : ((t % 2 == 0) ? ch0_rdata : ch1_rdata);
          if (req_size == 0) raw = raw & 32'hFF;
          else if (req_size == 1) raw = raw & 32'hFFFF;
          m_rdata = raw;
        end
      end else if (rsp_ready) m_rv = 0;
      if (cfg_ld && cfg_idx < 5) m_base[cfg_idx] = cfg_base & ~32'h3;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int t;
      bit acc;
      logic [4:0] es;
      t = m_find(req_addr);
      acc = req_valid && (!m_rv || rsp_ready);
      es = (acc && t >= 0) ? (5'b1 << t) : 5'b0;
      check({cur, " R10 req_ready"}, {31'b0, req_ready}, {31'b0, (!m_rv || rsp_ready)});
      check({cur, " R5/R9 tgt_sel"}, {27'b0, tgt_sel}, {27'b0, es});
      check({cur, " R10 rsp_valid"}, {31'b0, rsp_valid}, {31'b0, m_rv});
      if (m_rv) begin
        check({cur, " R6/R8 rsp_rdata"}, rsp_rdata, m_rdata);
        check({cur, " R5/R6 rsp_claim"}, {31'b0, rsp_claim}, {31'b0, m_claim});
      end
      if (es != 0) begin
        logic [3:0] eo;
        if (t < 2) eo = 4'(req_addr & 7);
        else if (t < 4) eo = 4'(8 + (req_addr & 3));
        else eo = 4'(req_addr & 15);
        check({cur, (t < 2) ? " R2" : (t < 4) ? " R3" : " R4", " offset"},
              {28'b0, tgt_offset}, {28'b0, eo});
        check({cur, " R9 tgt_wr"}, {31'b0, tgt_wr}, {31'b0, req_write});
        if (req_write)
          check({cur, " R7 tgt_wdata"}, tgt_wdata, (t == 4) ? (req_wdata & 32'hFF) : req_wdata);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      rsp_ready = stall ? (cyc % 3 == 0) : 1'b1;
    end
  end

  // assumes call at posedge+1; returns at posedge+1 after acceptance
  task automatic access(input bit w, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load(input logic [2:0] i, input logic [31:0] v);
    cfg_ld = 1; cfg_idx = i; cfg_base = v;
    @(posedge clk); #1;
    cfg_ld = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R10 reset rsp_valid", {31'b0, rsp_valid}, 0);
    check("R10 reset req_ready", {31'b0, req_ready}, 1);
    check("R9 reset tgt_sel", {27'b0, tgt_sel}, 0);
    @(posedge clk); #1;

    cur = "R1";
    load(0, 32'h1F3); load(1, 32'h172); load(2, 32'h3F6);
    load(3, 32'h377); load(4, 32'hC001);
    load(6, 32'h500);
    req_valid = 1; req_write = 0; req_addr = 32'h1F0; req_size = 2;
    @(negedge clk);
    check("R1 masked base hit", {27'b0, tgt_sel}, 5'b00001);
    req_addr = 32'h500;
    #1 check("R1 slot 6 ignored", {27'b0, tgt_sel}, 5'b00000);
    @(posedge clk); #1; idle(1);

    cur = "R2";
    for (int o = 0; o < 8; o++) access(0, 32'h1F0 + o, 2'(o % 3), 0);
    for (int o = 0; o < 8; o++) access(1, 32'h170 + o, 2, 32'hDEAD0000 + o);
    idle(2);
    cur = "R3";
    for (int o = 0; o < 4; o++) access(0, 32'h3F4 + o, 2'(o), 0);
    for (int o = 0; o < 4; o++) access(1, 32'h374 + o, 0, 32'h12345678);
    cur = "R4";
    for (int o = 0; o < 16; o++) access(o % 2, 32'hC000 + o, 2'(o % 4), 32'hCAFEBA00 + o);
    cur = "R8";
    access(0, 32'h1F1, 1, 0); access(0, 32'h171, 0, 0); access(0, 32'hC00F, 2, 0);
    cur = "R6";
    access(0, 32'h1234, 0, 0); access(1, 32'h1234, 2, 32'hFFFF); access(0, 32'h1F8, 2, 0);
    idle(2);

    cur = "R5";
    load(2, 32'h1F0); load(4, 32'h1F0);
    for (int o = 0; o < 16; o++) access(0, 32'h1F0 + o, 2, 0);
    load(1, 32'h1F0);
    access(0, 32'h1F2, 2, 0); access(1, 32'h1F3, 2, 32'h77);
    cur = "R2";
    load(0, 32'h2000); load(1, 32'h174); load(2, 32'h3F4); load(4, 32'hC008);
    access(0, 32'h174, 2, 0); access(0, 32'hC008, 2, 0); idle(2);

    cur = "R11";
    load(0, 32'h1F0);
    req_valid = 1; req_write = 0; req_addr = 32'h1F0; req_size = 2;
    cfg_ld = 1; cfg_idx = 0; cfg_base = 32'h2000;
    @(negedge clk);
    check("R11 old base decides", {27'b0, tgt_sel}, 5'b00001);
    @(posedge clk); #1;
    cfg_ld = 0;
    @(negedge clk);
    check("R11 new base in force", {27'b0, tgt_sel}, 5'b00000);
    @(posedge clk); #1; idle(2);

    cur = "R10";
    load(0, 32'h1F0); load(4, 32'hC000);
    stall = 1;
    for (int k = 0; k < 24; k++)
      access(k % 2, (k % 3 == 0) ? 32'h1F0 + k % 8 : (k % 3 == 1) ? 32'hC000 + k % 16 : 32'h9990,
             2'(k % 4), 32'h01020304 * k);
    idle(8);
    stall = 0;
    idle(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule